// File: doc/BRIEF.md
# Two-way set-associative address translation buffer

This block caches page translations for a 32-bit effective address space. The upper 20 bits of an effective address form the virtual page number. The block looks that number up in a table of 64 sets with two ways each. On a hit it returns the 20-bit physical page number joined to the unchanged 12-bit page offset, along with the entry's protection bits. The result appears one cycle after the request is accepted.

On a miss the block raises a refill request that carries the missing page number. It then stalls new lookups until exactly one new entry arrives on the refill port, and writes that entry into a free way or into the least-recently-used way of the set. Each entry keeps a referenced flag and a changed flag. When a lookup sets either flag for the first time, the block emits a one-cycle write-back pulse so the page table can record the access.

A parameter builds the instruction-side variant, which treats every access as a non-store. Two invalidate inputs are provided: one clears the whole buffer, the other clears a single set.

Top module: `tlb2w`

## Requirements
- R1: A synchronous reset marks every entry invalid, raises `req_ready`, and drops `rsp_valid`, `fill_req` and `wb_valid`. This holds even while a refill is pending.
- R2: A request accepted on a clock edge (`req_valid` high and `req_ready` high) produces a one-cycle `rsp_valid` after that edge. Exactly one of `rsp_hit` and `rsp_miss` is high at the same time.
- R3: `rsp_pa[11:0]` equals `req_ea[11:0]`. On a hit `rsp_pa[31:12]` is the stored physical page number; on a miss it is zero.
- R4: After a miss, `fill_req` stays high with `fill_vpn` = `req_ea[31:12]` and `req_ready` stays low until `fill_valid` is seen. A request offered meanwhile is not accepted. A `fill_valid` with no refill pending writes nothing.
- R5: The set index is `req_ea[17:12]` and the tag is `req_ea[31:18]`. Two pages with the same index and different tags are held at once.
- R6: A refill writes way 0 if it is invalid, else way 1 if it is invalid, else the least-recently-used way. Both the refilled way and a hit way become most recently used.
- R7: A hit on an entry whose referenced flag is clear sets the flag. In the next cycle it pulses `wb_valid` with `wb_vpn` = page number, `wb_r` = 1 and `wb_c` = the entry's changed flag. A hit that changes no flag gives no pulse.
- R8: Access kind encoding: 2'b00 load, 2'b01 store, 2'b10 fetch. A store hit on an entry whose changed flag is clear sets both flags and pulses `wb_valid` with `wb_c` = 1.
- R9: With `INSTR_SIDE` = 1 a store is handled as a load: the changed flag is never set and `wb_c` is never 1.
- R10: `inv_all` invalidates every entry in one cycle.
- R11: `inv_set` invalidates both ways of set `inv_set_idx` only; other sets keep their entries.
- R12: `rsp_prot` on a hit returns the protection bits supplied when the entry was refilled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup can be accepted (no refill pending) |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_pa | output | 32 | Physical address |
| rsp_prot | output | 2 | Protection bits of the hit entry |
| fill_req | output | 1 | Refill wanted |
| fill_vpn | output | 20 | Page number to refill |
| fill_valid | input | 1 | Refill entry present |
| fill_ppn | input | 20 | Refill physical page number |
| fill_prot | input | 2 | Refill protection bits |
| fill_r | input | 1 | Refill referenced flag |
| fill_c | input | 1 | Refill changed flag |
| wb_valid | output | 1 | Recording-flag write-back pulse |
| wb_vpn | output | 20 | Page number to update in the table |
| wb_r | output | 1 | New referenced flag |
| wb_c | output | 1 | New changed flag |
| inv_all | input | 1 | Invalidate all entries |
| inv_set | input | 1 | Invalidate one set |
| inv_set_idx | input | 6 | Set to invalidate |

## Verification
The assertions assume that the refill source never returns an entry for a page already resident in the addressed set. That assumption is what keeps at most one way matching. The stimulus respects it by refilling only in answer to a raised `fill_req`, with the page it names. The assertions also assume `req_kind` never carries 2'b11; the bench uses only the three defined kinds. Invalidates and resets are driven only between lookups, so no check depends on the ordering of an invalidate and a lookup in the same cycle.

// File: rtl/tlb2w_pkg.sv
package tlb2w_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_e;
endpackage

// File: rtl/tlb2w_way.sv
module tlb2w_way #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 14,
  parameter int PPN_W  = 20,
  parameter int PROT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PROT_W-1:0] lk_prot,
  output logic              lk_r,
  output logic              lk_c,
  input  logic [IDX_W-1:0]  fl_idx,
  output logic              fl_vld,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              wr_r,
  input  logic              wr_c,
  input  logic              mark_en,
  input  logic [IDX_W-1:0]  mark_idx,
  input  logic              mark_c,
  input  logic              inv_all,
  input  logic              inv_set_en,
  input  logic [IDX_W-1:0]  inv_set_idx
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [PPN_W-1:0]  ppn_mem  [SETS];
  logic [PROT_W-1:0] prot_mem [SETS];
  logic [SETS-1:0]   vld;
  logic [SETS-1:0]   rbit;
  logic [SETS-1:0]   cbit;

  // Payload arrays carry no reset so they map onto plain memory.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[fl_idx]  <= wr_tag;
      ppn_mem[fl_idx]  <= wr_ppn;
      prot_mem[fl_idx] <= wr_prot;
    end
  end

  // Valid bits live in flops so that a whole-buffer clear takes one cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (wr_en)      vld[fl_idx]      <= 1'b1;
      if (inv_set_en) vld[inv_set_idx] <= 1'b0;
      if (inv_all)    vld              <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbit <= '0;
      cbit <= '0;
    end else if (wr_en) begin
      rbit[fl_idx] <= wr_r;
      cbit[fl_idx] <= wr_c;
    end else if (mark_en) begin
      rbit[mark_idx] <= 1'b1;
      if (mark_c) cbit[mark_idx] <= 1'b1;
    end
  end

  assign lk_hit  = vld[lk_idx] && (tag_mem[lk_idx] == lk_tag);
  assign lk_ppn  = ppn_mem[lk_idx];
  assign lk_prot = prot_mem[lk_idx];
  assign lk_r    = rbit[lk_idx];
  assign lk_c    = cbit[lk_idx];
  assign fl_vld  = vld[fl_idx];

  AST_WR_MARK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && mark_en)); // R7
endmodule

// File: rtl/tlb2w_repl.sv
module tlb2w_repl #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] q_idx,
  input  logic [1:0]       q_vld,
  output logic             victim
);
  localparam int SETS = 1 << IDX_W;

  // One bit per set naming the least recently used way.
  logic [SETS-1:0] lru;

  always_ff @(posedge clk) begin
    if (rst)           lru <= '0;
    else if (touch_en) lru[touch_idx] <= ~touch_way;
  end

  always_comb begin
    if (!q_vld[0])      victim = 1'b0;
    else if (!q_vld[1]) victim = 1'b1;
    else                victim = lru[q_idx];
  end
endmodule

// File: rtl/tlb2w.sv
module tlb2w
  import tlb2w_pkg::*;
#(
  parameter int EA_W       = 32,
  parameter int OFS_W      = 12,
  parameter int IDX_W      = 6,
  parameter int PROT_W     = 2,
  parameter bit INSTR_SIDE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [EA_W-1:0]       req_ea,
  input  logic [1:0]            req_kind,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic                  rsp_miss,
  output logic [EA_W-1:0]       rsp_pa,
  output logic [PROT_W-1:0]     rsp_prot,
  output logic                  fill_req,
  output logic [EA_W-OFS_W-1:0] fill_vpn,
  input  logic                  fill_valid,
  input  logic [EA_W-OFS_W-1:0] fill_ppn,
  input  logic [PROT_W-1:0]     fill_prot,
  input  logic                  fill_r,
  input  logic                  fill_c,
  output logic                  wb_valid,
  output logic [EA_W-OFS_W-1:0] wb_vpn,
  output logic                  wb_r,
  output logic                  wb_c,
  input  logic                  inv_all,
  input  logic                  inv_set,
  input  logic [IDX_W-1:0]      inv_set_idx
);
  localparam int VPN_W = EA_W - OFS_W;
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAYS  = 2;

  logic [VPN_W-1:0] vpn;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             pending;
  logic [VPN_W-1:0] pend_vpn;
  logic             req_fire, fill_fire, is_store;

  logic [WAYS-1:0]   hit_w, fl_vld_w, wr_en_w, mark_en_w;
  logic [VPN_W-1:0]  ppn_w  [WAYS];
  logic [PROT_W-1:0] prot_w [WAYS];
  logic [WAYS-1:0]   r_w, c_w;

  logic              hit_any, hit_way, victim;
  logic [VPN_W-1:0]  sel_ppn;
  logic [PROT_W-1:0] sel_prot;
  logic              sel_r, sel_c, need_r, need_c, mark;
  logic              touch_en, touch_way;
  logic [IDX_W-1:0]  touch_idx;

  assign vpn       = req_ea[EA_W-1:OFS_W];
  assign idx       = vpn[IDX_W-1:0];
  assign tag       = vpn[VPN_W-1:IDX_W];
  assign req_ready = !pending;
  assign req_fire  = req_valid && !pending;
  assign fill_fire = fill_valid && pending;
  assign fill_req  = pending;
  assign fill_vpn  = pend_vpn;

  generate
    if (INSTR_SIDE) begin : g_instr
      assign is_store = 1'b0;
    end else begin : g_data
      assign is_store = (req_kind == ACC_STORE);
    end
  endgenerate

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign wr_en_w[w]   = fill_fire && (victim == w[0]);
      assign mark_en_w[w] = mark && (hit_way == w[0]);
      tlb2w_way #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(VPN_W), .PROT_W(PROT_W)
      ) u_way (
        .clk        (clk),
        .rst        (rst),
        .lk_idx     (idx),
        .lk_tag     (tag),
        .lk_hit     (hit_w[w]),
        .lk_ppn     (ppn_w[w]),
        .lk_prot    (prot_w[w]),
        .lk_r       (r_w[w]),
        .lk_c       (c_w[w]),
        .fl_idx     (pend_vpn[IDX_W-1:0]),
        .fl_vld     (fl_vld_w[w]),
        .wr_en      (wr_en_w[w]),
        .wr_tag     (pend_vpn[VPN_W-1:IDX_W]),
        .wr_ppn     (fill_ppn),
        .wr_prot    (fill_prot),
        .wr_r       (fill_r),
        .wr_c       (fill_c),
        .mark_en    (mark_en_w[w]),
        .mark_idx   (idx),
        .mark_c     (need_c),
        .inv_all    (inv_all),
        .inv_set_en (inv_set),
        .inv_set_idx(inv_set_idx)
      );
    end
  endgenerate

  assign hit_any  = |hit_w;
  assign hit_way  = hit_w[1];
  assign sel_ppn  = ppn_w[hit_way];
  assign sel_prot = prot_w[hit_way];
  assign sel_r    = r_w[hit_way];
  assign sel_c    = c_w[hit_way];
  assign need_r   = !sel_r;
  assign need_c   = is_store && !sel_c;
  assign mark     = req_fire && hit_any && (need_r || need_c);

  // A lookup and a refill never share a cycle: ready gates one, pending the other.
  assign touch_en  = (req_fire && hit_any) || fill_fire;
  assign touch_idx = fill_fire ? pend_vpn[IDX_W-1:0] : idx;
  assign touch_way = fill_fire ? victim : hit_way;

  tlb2w_repl #(.IDX_W(IDX_W)) u_repl (
    .clk      (clk),
    .rst      (rst),
    .touch_en (touch_en),
    .touch_idx(touch_idx),
    .touch_way(touch_way),
    .q_idx    (pend_vpn[IDX_W-1:0]),
    .q_vld    (fl_vld_w),
    .victim   (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_pa    <= '0;
      rsp_prot  <= '0;
      pending   <= 1'b0;
      pend_vpn  <= '0;
      wb_valid  <= 1'b0;
      wb_vpn    <= '0;
      wb_r      <= 1'b0;
      wb_c      <= 1'b0;
    end else begin
      rsp_valid <= req_fire;
      rsp_hit   <= req_fire && hit_any;
      rsp_miss  <= req_fire && !hit_any;
      if (req_fire) begin
        rsp_pa   <= {(hit_any ? sel_ppn : {VPN_W{1'b0}}), req_ea[OFS_W-1:0]};
        rsp_prot <= hit_any ? sel_prot : {PROT_W{1'b0}};
      end
      wb_valid <= mark;
      if (mark) begin
        wb_vpn <= vpn;
        wb_r   <= 1'b1;
        wb_c   <= sel_c || need_c;
      end
      if (req_fire && !hit_any) begin
        pending  <= 1'b1;
        pend_vpn <= vpn;
      end else if (fill_fire) begin
        pending  <= 1'b0;
      end
    end
  end

  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss)); // R2
  AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_pa[OFS_W-1:0] == $past(req_ea[OFS_W-1:0]))); // R3
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_pa[EA_W-1:OFS_W] == '0)); // R3
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (!req_ready && fill_req)); // R4
  AST_SINGLE_WAY_HIT: assert property (@(posedge clk) disable iff (rst)
    req_fire |-> $onehot0(hit_w)); // R5
  AST_WB_ON_HIT: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (rsp_hit && wb_r)); // R7
  AST_INSTR_NO_CHG: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (!INSTR_SIDE || !wb_c)); // R9
endmodule

// File: tb/sim_tlb2w.sv
module sim_tlb2w;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_kind = 2'b00;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  fill_prot = '0;
  logic        fill_r = 1'b0, fill_c = 1'b0;
  logic        inv_all = 1'b0, inv_set = 1'b0;
  logic [5:0]  inv_set_idx = '0;

  logic        req_ready, rsp_valid, rsp_hit, rsp_miss, fill_req, wb_valid, wb_r, wb_c;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_prot;
  logic [19:0] fill_vpn, wb_vpn;
  logic        i_ready, i_rsp_valid, i_hit, i_miss, i_fill_req, i_wb_valid, i_wb_r, i_wb_c;
  logic [31:0] i_pa;
  logic [1:0]  i_prot;
  logic [19:0] i_fill_vpn, i_wb_vpn;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb2w u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_kind(req_kind), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_prot(rsp_prot), .fill_req(fill_req),
    .fill_vpn(fill_vpn), .fill_valid(fill_valid), .fill_ppn(fill_ppn),
    .fill_prot(fill_prot), .fill_r(fill_r), .fill_c(fill_c), .wb_valid(wb_valid),
    .wb_vpn(wb_vpn), .wb_r(wb_r), .wb_c(wb_c), .inv_all(inv_all),
    .inv_set(inv_set), .inv_set_idx(inv_set_idx)
  );

  tlb2w #(.INSTR_SIDE(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(i_ready),
    .req_ea(req_ea), .req_kind(req_kind), .rsp_valid(i_rsp_valid), .rsp_hit(i_hit),
    .rsp_miss(i_miss), .rsp_pa(i_pa), .rsp_prot(i_prot), .fill_req(i_fill_req),
    .fill_vpn(i_fill_vpn), .fill_valid(fill_valid), .fill_ppn(fill_ppn),
    .fill_prot(fill_prot), .fill_r(fill_r), .fill_c(fill_c), .wb_valid(i_wb_valid),
    .wb_vpn(i_wb_vpn), .wb_r(i_wb_r), .wb_c(i_wb_c), .inv_all(inv_all),
    .inv_set(inv_set), .inv_set_idx(inv_set_idx)
  );

  // Row: {ea[31:0], kind[1:0], exp_hit, exp_wb, exp_wb_c}
  localparam logic [36:0] VEC [NVEC] = '{
    {32'h0001_2345, 2'b00, 1'b0, 1'b0, 1'b0},
    {32'h0001_2355, 2'b00, 1'b1, 1'b1, 1'b0},
    {32'h0001_2000, 2'b00, 1'b1, 1'b0, 1'b0},
    {32'h0001_2004, 2'b01, 1'b1, 1'b1, 1'b1},
    {32'h0001_2008, 2'b01, 1'b1, 1'b0, 1'b0},
    {32'h0401_2000, 2'b10, 1'b0, 1'b0, 1'b0},
    {32'h0401_2FFF, 2'b10, 1'b1, 1'b1, 1'b0},
    {32'h0001_2ABC, 2'b00, 1'b1, 1'b0, 1'b0},
    {32'h0801_2000, 2'b00, 1'b0, 1'b0, 1'b0},
    {32'h0801_2010, 2'b00, 1'b1, 1'b1, 1'b0},
    {32'h0401_2000, 2'b00, 1'b0, 1'b0, 1'b0},
    {32'h0401_2020, 2'b00, 1'b1, 1'b1, 1'b0},
    {32'h0001_2000, 2'b00, 1'b0, 1'b0, 1'b0},
    {32'h0001_2040, 2'b00, 1'b1, 1'b1, 1'b0},
    {32'h0401_2000, 2'b00, 1'b1, 1'b0, 1'b0},
    {32'h0801_2000, 2'b00, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [19:0] ppn_of(input logic [19:0] v);
    return v ^ 20'h5A5A5;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] ea, input logic [1:0] kind);
    @(negedge clk);
    req_ea = ea; req_kind = kind; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refill(input logic [19:0] v);
    @(negedge clk);
    fill_valid = 1'b1; fill_ppn = ppn_of(v); fill_prot = v[1:0];
    fill_r = 1'b0; fill_c = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic miss_fill(input logic [31:0] ea, input string tag);
    look(ea, 2'b00);
    chk(tag, {63'd0, rsp_miss}, 64'd1);
    refill(ea[31:12]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    chk("R1 ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
    chk("R1 fill_req after reset", {63'd0, fill_req}, 64'd0);
    chk("R1 wb_valid after reset", {63'd0, wb_valid}, 64'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] ea;
      logic [19:0] v;
      ea = VEC[i][36:5];
      v  = ea[31:12];
      look(ea, VEC[i][4:3]);
      chk("R2 rsp_valid", {63'd0, rsp_valid}, 64'd1);
      chk("R5 R6 hit", {63'd0, rsp_hit}, {63'd0, VEC[i][2]});
      chk("R2 miss flag", {63'd0, rsp_miss}, {63'd0, !VEC[i][2]});
      if (VEC[i][2]) begin
        chk("R3 pa on hit", {32'd0, rsp_pa}, {32'd0, ppn_of(v), ea[11:0]});
        chk("R12 prot", {62'd0, rsp_prot}, {62'd0, v[1:0]});
      end else begin
        chk("R3 pa on miss", {32'd0, rsp_pa}, {52'd0, ea[11:0]});
        chk("R4 fill_req", {63'd0, fill_req}, 64'd1);
        chk("R4 fill_vpn", {44'd0, fill_vpn}, {44'd0, v});
        chk("R4 ready low", {63'd0, req_ready}, 64'd0);
      end
      chk("R7 wb_valid", {63'd0, wb_valid}, {63'd0, VEC[i][1]});
      if (VEC[i][1]) begin
        chk("R8 wb_c", {63'd0, wb_c}, {63'd0, VEC[i][0]});
        chk("R7 wb_vpn", {44'd0, wb_vpn}, {44'd0, v});
        chk("R7 wb_r", {63'd0, wb_r}, 64'd1);
      end
      if (!VEC[i][2]) begin
        refill(v);
        chk("R4 fill_req cleared", {63'd0, fill_req}, 64'd0);
      end
    end

    // R9: instruction-side instance never sets the changed flag
    look(32'h0033_3000, 2'b01);
    chk("R9 data side miss", {63'd0, rsp_miss}, 64'd1);
    chk("R9 instr side miss", {63'd0, i_miss}, 64'd1);
    refill(20'h00333);
    look(32'h0033_3004, 2'b01);
    chk("R8 data store wb_c", {62'd0, wb_valid, wb_c}, 64'd3);
    chk("R9 instr store wb_c", {62'd0, i_wb_valid, i_wb_c}, 64'd2);
    look(32'h0033_3008, 2'b01);
    chk("R8 data second store no wb", {63'd0, wb_valid}, 64'd0);
    chk("R9 instr second store no wb", {63'd0, i_wb_valid}, 64'd0);

    // R4: a fill with nothing pending is ignored; stall while pending
    refill(20'h00777);
    look(32'h0077_7000, 2'b00);
    chk("R4 stray fill ignored", {63'd0, rsp_miss}, 64'd1);
    look(32'h0055_5000, 2'b00);
    chk("R4 no accept while pending", {63'd0, rsp_valid}, 64'd0);
    chk("R4 fill_vpn held", {44'd0, fill_vpn}, 64'h00777);
    refill(20'h00777);
    look(32'h0077_7000, 2'b00);
    chk("R4 hit after refill", {63'd0, rsp_hit}, 64'd1);

    // R11: per-set invalidate
    miss_fill(32'h0010_5000, "R11 setup set 5");
    miss_fill(32'h0010_7000, "R11 setup set 7");
    @(negedge clk); inv_set = 1'b1; inv_set_idx = 6'h05;
    @(negedge clk); inv_set = 1'b0;
    look(32'h0010_5000, 2'b00);
    chk("R11 set 5 cleared", {63'd0, rsp_miss}, 64'd1);
    refill(20'h00105);
    look(32'h0010_7000, 2'b00);
    chk("R11 set 7 kept", {63'd0, rsp_hit}, 64'd1);
    chk("R12 prot set 7", {62'd0, rsp_prot}, 64'd3);

    // R10: global invalidate
    @(negedge clk); inv_all = 1'b1;
    @(negedge clk); inv_all = 1'b0;
    look(32'h0010_7000, 2'b00);
    chk("R10 all cleared", {63'd0, rsp_miss}, 64'd1);
    refill(20'h00107);

    // R1: reset while a refill is pending
    look(32'h0099_9000, 2'b00);
    chk("R1 pending before reset", {63'd0, fill_req}, 64'd1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 ready after mid reset", {63'd0, req_ready}, 64'd1);
    chk("R1 fill_req after mid reset", {63'd0, fill_req}, 64'd0);
    look(32'h0010_7000, 2'b00);
    chk("R1 entries invalid after reset", {63'd0, rsp_miss}, 64'd1);
    refill(20'h00107);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule